// File: doc/BRIEF.md
# Hamming-Weight Banded Minterm Order Generator

This block produces every value of an `N_BITS`-wide input space exactly once, one value per valid/ready transfer. Its default order is a banded one. The all-zeros value comes first. Next come all values with a single set bit, then all values with two set bits, and so on, up to the all-ones value, which comes last and carries a last flag. Within a band the order is scrambled by a seedable LFSR. The same seed always gives the same sequence, and different seeds give different orders. A mode input selects plain ascending binary order instead.

A synthesis engine uses the stream to visit minterms in an order where no later minterm is covered by an earlier one. In such an order, fixing a later row never has to disturb rows that are already complete. A separate combinational comparator is included on the same block. It reports whether a pair (later, earlier) is in this blocking relation, so the consumer can vet its own candidate orders.

Inside a band, the generator scans the space from an LFSR-chosen start with an LFSR-chosen odd stride. An odd stride is coprime with the power-of-two space size, so one scan visits every value. A visited mask of one bit per minterm prevents repeats. A scan that finds no fresh member of the current band moves the generator to the next band.

Top module: `mto_order_gen`

## Requirements
- R1: After reset, and until `start` is first asserted, `out_valid` is 0.
- R2: After `start`, exactly `2**N_BITS` transfers occur, each carrying a distinct value. After the final transfer, `out_valid` stays 0 until the next `start`.
- R3: The first transferred value is all-zeros and the final one is all-ones. `out_last` is 1 with the all-ones value and 0 with every other value.
- R4: With `natural_mode`=0, the number of set bits in successive transferred values never decreases.
- R5: With either mode, no transferred value is blocked by any earlier transferred value. A value L is blocked by an earlier value E when (L & E) == L.
- R6: Two sequences started with the same `seed_in` and the same mode are identical, whatever the `out_ready` pattern.
- R7: With `natural_mode`=0, seeds 16'h1234 and 16'hACE1 produce different orders.
- R8: With `natural_mode`=1, the values are 0, 1, 2, …, `2**N_BITS-1` in ascending order.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_minterm` and `out_last` hold their values into the next cycle.
- R10: `chk_blocked` is 1 exactly when (`chk_later` & `chk_earlier`) == `chk_later`. For example, later 101 with earlier 111 gives 1, and later 110 with earlier 011 gives 0.
- R11: Asserting `start` in the middle of a sequence abandons it. The new sequence behaves as if started from idle.
- R12: A seed of zero is accepted and yields a complete banded order satisfying R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new sequence, capturing seed and mode |
| seed_in | input | SEED_W | LFSR seed for the in-band scramble |
| natural_mode | input | 1 | 1 selects ascending binary order |
| out_ready | input | 1 | Consumer accepts the offered value |
| out_valid | output | 1 | A value is offered |
| out_minterm | output | N_BITS | Offered value |
| out_last | output | 1 | Offered value is the final one |
| chk_later | input | N_BITS | Comparator: later value |
| chk_earlier | input | N_BITS | Comparator: earlier value |
| chk_blocked | output | 1 | Comparator: later is covered by earlier |

## Verification
The bench uses random backpressure and targets several failure modes. A stride that is not forced odd would skip values, which would show up as a missing minterm or a run that never ends. A visited mask that fails to clear on restart would drop values from the second sequence. A band advance that fires too early would let a heavier value come before a lighter one, which the bench sees as both a band violation and a blocking pair. It also compares sequences started from equal and from unequal seeds, including a seed restarted mid-run and a zero seed that must not lock the LFSR. Finally, it sweeps the comparator over every pair of values and checks the handshake hold on every stalled cycle.

// File: rtl/mto_pkg.sv
// Package: shared types and helpers for the banded minterm order generator.
// Assumes minterm widths of at most 31 bits.
package mto_pkg;

    typedef logic [5:0] weight_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_SCAN = 2'd2,
        ST_HOLD = 2'd3
    } gen_state_t;

    // Number of set bits in a 32-bit word.
    function automatic weight_t pop32(input logic [31:0] v);
        weight_t n;
        n = '0;
        for (int i = 0; i < 32; i++) begin
            n = n + weight_t'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/mto_lfsr.sv
// Galois LFSR with seed load. A zero seed is replaced by 1 so the register
// never locks up. Exposes a low slice (scan start) and a high slice (stride).
// Assumes OUT_W <= W.
module mto_lfsr #(
    parameter int          W     = 16,
    parameter int          OUT_W = 4,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     seed,
    input  logic             step,
    output logic [OUT_W-1:0] draw_lo,
    output logic [OUT_W-1:0] draw_hi
);
    logic [W-1:0] state_q;

    // Load seed, or advance one Galois shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W'(1);
        end else if (load) begin
            state_q <= (seed == '0) ? W'(1) : seed;
        end else if (step) begin
            state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
        end
    end

    assign draw_lo = state_q[OUT_W-1:0];
    assign draw_hi = state_q[W-1 -: OUT_W];
endmodule

// File: rtl/mto_scan.sv
// Candidate walker: visits start, start+stride, start+2*stride, ... modulo
// 2**IDX_W. The stride is forced odd, so one full walk covers every index.
module mto_scan #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             draw,
    input  logic [IDX_W-1:0] draw_start,
    input  logic [IDX_W-1:0] draw_stride,
    input  logic             advance,
    output logic [IDX_W-1:0] cand,
    output logic             exhausted
);
    logic [IDX_W-1:0] stride_q;
    logic [IDX_W-1:0] probes_q;

    // Start a new walk, or step to the next candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand     <= '0;
            stride_q <= IDX_W'(1);
            probes_q <= '0;
        end else if (draw) begin
            cand     <= draw_start;
            stride_q <= draw_stride | IDX_W'(1);
            probes_q <= '0;
        end else if (advance) begin
            cand     <= cand + stride_q;
            probes_q <= probes_q + IDX_W'(1);
        end
    end

    assign exhausted = &probes_q;
endmodule

// File: rtl/mto_visited.sv
// One flag per minterm, recording which values were already emitted.
// Cleared in one cycle; one flag set per cycle.
module mto_visited #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] probe_idx,
    output logic             probe_seen
);
    localparam int SPACE = 1 << IDX_W;

    logic [SPACE-1:0] mask_q;

    for (genvar g = 0; g < SPACE; g++) begin : g_flag
        // Clear on restart, set when this index is emitted.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                mask_q[g] <= 1'b0;
            end else if (set_en && (set_idx == IDX_W'(g))) begin
                mask_q[g] <= 1'b1;
            end
        end
    end

    assign probe_seen = mask_q[probe_idx];
endmodule

// File: rtl/mto_block_check.sv
// Combinational comparator: a later value is blocked when every set bit of it
// is also set in the earlier value.
module mto_block_check #(
    parameter int N_BITS = 4
) (
    input  logic [N_BITS-1:0] later,
    input  logic [N_BITS-1:0] earlier,
    output logic              blocked
);
    // Subset test on the set bits.
    always_comb begin
        blocked = ((later & ~earlier) == '0);
    end
endmodule

// File: rtl/mto_order_gen.sv
// Top: emits all 2**N_BITS minterms once each over a valid/ready port, in
// Hamming-weight bands with LFSR-scrambled order inside a band, or in
// ascending order when natural_mode is captured high at start.
// Assumes N_BITS < 32 and N_BITS <= SEED_W.
module mto_order_gen #(
    parameter int          N_BITS = 4,
    parameter int          SEED_W = 16,
    parameter logic [SEED_W-1:0] TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEED_W-1:0] seed_in,
    input  logic              natural_mode,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [N_BITS-1:0] out_minterm,
    output logic              out_last,
    input  logic [N_BITS-1:0] chk_later,
    input  logic [N_BITS-1:0] chk_earlier,
    output logic              chk_blocked
);
    import mto_pkg::*;

    localparam int IDX_W = N_BITS;

    gen_state_t       state_q;
    weight_t          band_q;
    logic             natural_q;
    logic [IDX_W-1:0] nat_ctr_q;
    logic [IDX_W-1:0] cur_q;
    logic             last_q;

    logic [IDX_W-1:0] rnd_start, rnd_stride, cand;
    logic             exhausted, seen;
    logic [IDX_W-1:0] probe;
    logic             take, do_draw, do_advance, do_set;

    // Probe selection and acceptance for the current cycle.
    always_comb begin
        probe      = natural_q ? nat_ctr_q : cand;
        take       = natural_q || ((pop32(32'(cand)) == band_q) && !seen);
        do_draw    = (state_q == ST_LOAD) && !start;
        do_set     = (state_q == ST_SCAN) && take && !start;
        do_advance = (state_q == ST_SCAN) && !take && !exhausted && !start;
    end

    mto_lfsr #(.W(SEED_W), .OUT_W(IDX_W), .TAPS(TAPS)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .seed    (seed_in),
        .step    (do_draw),
        .draw_lo (rnd_start),
        .draw_hi (rnd_stride)
    );

    mto_scan #(.IDX_W(IDX_W)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .draw        (do_draw),
        .draw_start  (rnd_start),
        .draw_stride (rnd_stride),
        .advance     (do_advance),
        .cand        (cand),
        .exhausted   (exhausted)
    );

    mto_visited #(.IDX_W(IDX_W)) u_visited (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .set_en     (do_set),
        .set_idx    (probe),
        .probe_idx  (cand),
        .probe_seen (seen)
    );

    mto_block_check #(.N_BITS(N_BITS)) u_block (
        .later   (chk_later),
        .earlier (chk_earlier),
        .blocked (chk_blocked)
    );

    // Sequencer: restart, draw a walk, scan for a fresh band member, offer it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            band_q    <= '0;
            natural_q <= 1'b0;
            nat_ctr_q <= '0;
            cur_q     <= '0;
            last_q    <= 1'b0;
        end else if (start) begin
            state_q   <= ST_LOAD;
            band_q    <= '0;
            natural_q <= natural_mode;
            nat_ctr_q <= '0;
            last_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_LOAD: state_q <= ST_SCAN;
                ST_SCAN: begin
                    if (take) begin
                        cur_q   <= probe;
                        last_q  <= &probe;
                        state_q <= ST_HOLD;
                        if (natural_q) nat_ctr_q <= nat_ctr_q + IDX_W'(1);
                    end else if (exhausted) begin
                        band_q  <= band_q + weight_t'(1);
                        state_q <= ST_LOAD;
                    end
                end
                ST_HOLD: begin
                    if (out_ready) state_q <= last_q ? ST_IDLE : ST_LOAD;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign out_valid   = (state_q == ST_HOLD);
    assign out_minterm = cur_q;
    assign out_last    = last_q;
endmodule

// File: rtl/mto_order_gen_sva.sv
// Checker for mto_order_gen: handshake hold, first/last values, band order,
// idle after reset and comparator corner values. Bound to the top below.
module mto_order_gen_sva #(
    parameter int N_BITS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              natural_mode,
    input logic              out_ready,
    input logic              out_valid,
    input logic [N_BITS-1:0] out_minterm,
    input logic              out_last,
    input logic [N_BITS-1:0] chk_later,
    input logic [N_BITS-1:0] chk_earlier,
    input logic              chk_blocked
);
    import mto_pkg::*;

    logic    started_q, first_q, nat_q;
    weight_t prev_w_q;

    // Track sequence start, mode, and weight of the last accepted value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            first_q   <= 1'b0;
            nat_q     <= 1'b0;
            prev_w_q  <= '0;
        end else if (start) begin
            started_q <= 1'b1;
            first_q   <= 1'b1;
            nat_q     <= natural_mode;
            prev_w_q  <= '0;
        end else if (out_valid && out_ready) begin
            first_q   <= 1'b0;
            prev_w_q  <= pop32(32'(out_minterm));
        end
    end

    AST_IDLE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> !out_valid); // R1
    AST_FIRST_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && first_q) |-> (out_minterm == '0)); // R3
    AST_LAST_IS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (&out_minterm)); // R3
    AST_ONES_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (&out_minterm)) |-> out_last); // R3
    AST_BAND_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !nat_q && !first_q) |-> (pop32(32'(out_minterm)) >= prev_w_q)); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=>
        (out_valid && $stable(out_minterm) && $stable(out_last))); // R9
    AST_SELF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_later == chk_earlier) |-> chk_blocked); // R10
    AST_ZERO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_later == '0) |-> chk_blocked); // R10
endmodule

bind mto_order_gen mto_order_gen_sva #(.N_BITS(N_BITS)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .natural_mode (natural_mode),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .out_minterm  (out_minterm),
    .out_last     (out_last),
    .chk_later    (chk_later),
    .chk_earlier  (chk_earlier),
    .chk_blocked  (chk_blocked)
);

// File: tb/mto_order_gen_test.sv
// Bench: drives sequences under random backpressure, records every transfer
// in queues and checks them against the requirements; sweeps the comparator.
module mto_order_gen_test;
    localparam int N     = 4;
    localparam int SPACE = 1 << N;
    localparam int SW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [SW-1:0] seed_in = '0;
    logic          natural_mode = 1'b0;
    logic          out_ready = 1'b0;
    logic          out_valid;
    logic [N-1:0]  out_minterm;
    logic          out_last;
    logic [N-1:0]  chk_later = '0;
    logic [N-1:0]  chk_earlier = '0;
    logic          chk_blocked;

    int errors = 0;
    int checks = 0;

    int got[$];
    int lastf[$];
    int seq_a[$];

    mto_order_gen #(.N_BITS(N), .SEED_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed_in(seed_in),
        .natural_mode(natural_mode), .out_ready(out_ready),
        .out_valid(out_valid), .out_minterm(out_minterm), .out_last(out_last),
        .chk_later(chk_later), .chk_earlier(chk_earlier), .chk_blocked(chk_blocked)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int popc(input int v);
        int n = 0;
        for (int i = 0; i < N; i++) n += (v >> i) & 1;
        return n;
    endfunction

    // Start a sequence and collect up to max_x transfers.
    task automatic run_seq(input logic [SW-1:0] sd, input bit nat,
                           input int ready_pct, input int max_x);
        bit prev_stall = 0;
        int prev_m = 0;
        int guard = 0;
        got.delete();
        lastf.delete();
        @(negedge clk);
        seed_in = sd; natural_mode = nat; start = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        while (got.size() < max_x && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (prev_stall)
                check(out_valid && (int'(out_minterm) == prev_m), "R9",
                      "hold under stall", int'(out_minterm), prev_m);
            out_ready = ($urandom_range(99) < ready_pct);
            #1;
            if (out_valid && out_ready) begin
                got.push_back(int'(out_minterm));
                lastf.push_back(int'(out_last));
            end
            prev_stall = out_valid && !out_ready;
            prev_m = int'(out_minterm);
        end
        check(got.size() == max_x, "R2", "transfer count", got.size(), max_x);
    endtask

    // Check a complete collected sequence.
    task automatic analyze(input bit nat, input string tag);
        bit seen [SPACE];
        bit ok;
        foreach (seen[i]) seen[i] = 0;
        ok = 1;
        foreach (got[i]) begin
            if (seen[got[i]]) ok = 0;
            seen[got[i]] = 1;
        end
        check(ok && got.size() == SPACE, "R2", {tag, " distinct values"}, got.size(), SPACE);
        check(got[0] == 0, "R3", {tag, " first value"}, got[0], 0);
        check(got[SPACE-1] == SPACE-1, "R3", {tag, " final value"}, got[SPACE-1], SPACE-1);
        ok = 1;
        foreach (lastf[i]) if (lastf[i] != (i == SPACE-1)) ok = 0;
        check(ok, "R3", {tag, " last flag placement"}, 0, 1);
        ok = 1;
        for (int j = 1; j < SPACE; j++)
            for (int i = 0; i < j; i++)
                if ((got[j] & got[i]) == got[j]) ok = 0;
        check(ok, "R5", {tag, " no blocking pair"}, 0, 1);
        if (!nat) begin
            ok = 1;
            for (int i = 1; i < SPACE; i++) if (popc(got[i]) < popc(got[i-1])) ok = 0;
            check(ok, "R4", {tag, " band order"}, 0, 1);
        end else begin
            for (int i = 0; i < SPACE; i++)
                check(got[i] == i, "R8", {tag, " ascending"}, got[i], i);
        end
    endtask

    task automatic idle_after(input string tag);
        out_ready = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            check(!out_valid, "R2", {tag, " idle after final"}, int'(out_valid), 0);
        end
        out_ready = 1'b0;
    endtask

    function automatic bit same_as_a();
        if (got.size() != seq_a.size()) return 0;
        foreach (got[i]) if (got[i] != seq_a[i]) return 0;
        return 1;
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd77));
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid, "R1", "valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); out_ready = 1'b1; #1;
            check(!out_valid, "R1", "valid before start", int'(out_valid), 0);
        end
        out_ready = 1'b0;

        // R10: comparator over every pair, plus named examples.
        for (int l = 0; l < SPACE; l++)
            for (int e = 0; e < SPACE; e++) begin
                chk_later = N'(l); chk_earlier = N'(e); #1;
                check(chk_blocked == ((l & e) == l), "R10", "blocking relation",
                      int'(chk_blocked), int'((l & e) == l));
            end
        chk_later = 4'b0101; chk_earlier = 4'b0111; #1;
        check(chk_blocked == 1'b1, "R10", "101 after 111", int'(chk_blocked), 1);
        chk_later = 4'b0110; chk_earlier = 4'b0011; #1;
        check(chk_blocked == 1'b0, "R10", "110 after 011", int'(chk_blocked), 0);

        run_seq(16'h1234, 1'b0, 60, SPACE);
        analyze(1'b0, "seed 1234");
        seq_a = got;
        idle_after("seed 1234");

        run_seq(16'h1234, 1'b0, 30, SPACE);
        check(same_as_a(), "R6", "same seed repeats order", 0, 1);

        run_seq(16'hACE1, 1'b0, 80, SPACE);
        analyze(1'b0, "seed ACE1");
        check(!same_as_a(), "R7", "different seed differs", 1, 0);

        run_seq(16'h0000, 1'b0, 50, SPACE);
        analyze(1'b0, "R12 zero seed");

        run_seq(16'h0000, 1'b1, 70, SPACE);
        analyze(1'b1, "natural");
        idle_after("natural");

        // R11: abandon mid-run, then restart in each mode.
        run_seq(16'h5A5A, 1'b0, 100, 5);
        run_seq(16'h0000, 1'b1, 100, SPACE);
        analyze(1'b1, "R11 natural restart");
        run_seq(16'h5A5A, 1'b0, 100, 7);
        run_seq(16'h1234, 1'b0, 100, SPACE);
        check(same_as_a(), "R11", "restart reproduces seed order", 0, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule